// File: doc/BRIEF.md
# LCD Panel Row Timing Generator

This block produces the line-synchronous drive strobes for a small monochrome LCD panel. It runs on the system clock and advances once per pixel-clock period, signalled by a single-cycle enable (`hck_en`, one "tick"). A line-start pulse and a field-start pulse, both sampled on ticks, frame the picture. Inside each line the block counts HCK periods. Inside each field it counts video lines and panel rows.

From those counts it drives five active-low strobes:

- a field-start pulse for the panel (`vpl_n`),
- a row-pair clock (`vck_n`),
- a per-row start pulse (`hpl_n`),
- row-enable strobes for even rows (`rene_n`) and odd rows (`reno_n`).

It also passes the pixel-clock cadence to the panel as `hck_o`.

The panel has 240 rows, and the first row is video line 22. In 525-line mode every line from 22 onward is a row. In 625-line mode some lines are dropped at regular intervals so that the taller picture fits the same 240 rows. A dropped line produces no strobes and does not advance the row count.

Two controllers drive the strobes. A horizontal phase machine steps through these phases across a line:

- `H_START`: the row start pulse.
- `H_SETUP`: setup before the row-pair clock.
- `H_VCLK`: the row-pair clock.
- `H_GAP`: an optional gap, empty with the default parameters.
- `H_ROW`: the row enable.
- `H_TAIL`: the rest of the line. The counter holds here if a line runs long.

A vertical machine moves through three states:

- `V_BLANK`: lines before the first row.
- `V_ROWS`: rows being issued.
- `V_DONE`: all 240 rows issued.

Its transitions are as follows:

- `V_BLANK` goes to `V_ROWS` on line 22.
- `V_ROWS` goes to `V_DONE` at the first non-dropped line after the 240th row.
- A field start returns any state to `V_BLANK`.

Top module: `lcd_row_timer`

## Requirements
- R1: While `rst_n` is low, all five strobes are high and `hck_o` is low. The strobes go high at once, without waiting for a clock edge.
- R2: Line positions are counted as follows, and strobes change only after a tick.
  - A tick with `field_start` high begins line 1 of a field, and `field_odd` is captured on that tick (1 = odd field).
  - A tick with `line_start` high, and `field_start` low, begins the next line.
  - The tick that begins a line is position 0, and each later tick adds 1.
  - The strobe levels for position p appear after the tick that follows position p.
- R3: With `mode_625` = 0, video lines 22 through 261 are panel rows 0 through 239. A row with an even index is an even row.
- R4: `hpl_n` is low for position 0 of every row line and high elsewhere.
- R5: `vpl_n` is low for positions 0, 1 and 2 of the row-0 line only.
- R6: `vck_n` is low for positions 3, 4 and 5 of even rows only.
- R7: `rene_n` is low for positions 6 through 337 of even rows, and `reno_n` is low for the same positions of odd rows. The two are never low together.
- R8: With `mode_625` = 1, some lines are dropped and give no strobes. In the odd field these are lines 28, 34, 40 and so on, every 6 lines. In the even field they are lines 25, 31, 37 and so on, every 6 lines. Row 239 falls on line 308 in the odd field and on line 309 in the even field.
- R9: Lines before line 22, and every line after row 239, give no strobes.
- R10: `hck_o` is high for exactly the clock cycle after each tick and low otherwise, whatever the line and field state.
- R11: If a line runs past position 383 without a new line start, the position holds at 383 and no strobe repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hck_en | input | 1 | One-cycle enable marking each HCK period (tick) |
| line_start | input | 1 | Begins a new line when high on a tick |
| field_start | input | 1 | Begins line 1 of a field when high on a tick |
| field_odd | input | 1 | Field identity captured with field_start (1 = odd) |
| mode_625 | input | 1 | 0 = 525-line mode, 1 = 625-line mode with line dropping |
| hck_o | output | 1 | Horizontal clock to the panel, high the cycle after each tick |
| vpl_n | output | 1 | Field start pulse to the panel, active low |
| vck_n | output | 1 | Row-pair clock, active low |
| hpl_n | output | 1 | Row start pulse, active low |
| rene_n | output | 1 | Even row enable, active low |
| reno_n | output | 1 | Odd row enable, active low |

## Verification
Each strobe is due one tick after the position it belongs to, because the position and row flags are registered on one tick and the strobe registers load from them on the next. The bench therefore counts k from the line-start tick and expects the position-p level after tick k = p + 1. It samples on the falling edge after each tick, and also after any idle cycles inserted between ticks. `hck_o` is due on the clock edge that samples the tick, and the bench checks it one half-cycle later and again one cycle after that. Dropped lines and row limits are checked on whole 390-tick lines reached through a field of short lines.

// File: rtl/lcdrt_pkg.sv
package lcdrt_pkg;

    typedef enum logic [1:0] {
        V_BLANK,
        V_ROWS,
        V_DONE
    } vstate_t;

    typedef enum logic [2:0] {
        H_START,
        H_SETUP,
        H_VCLK,
        H_GAP,
        H_ROW,
        H_TAIL
    } hphase_t;

endpackage

// File: rtl/lcdrt_hphase.sv
module lcdrt_hphase
    import lcdrt_pkg::*;
#(
    parameter int LINE_LEN  = 384,
    parameter int HPL_LEN   = 1,
    parameter int VCK_START = 3,
    parameter int VCK_LEN   = 3,
    parameter int REN_GAP   = 5,
    parameter int REN_LEN   = 332
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  logic    line_begin,
    output hphase_t phase
);

    localparam int POS_W     = $clog2(LINE_LEN);
    localparam int VCK_END   = VCK_START + VCK_LEN;
    localparam int ROW_START = HPL_LEN + REN_GAP;
    localparam int ROW_END   = ROW_START + REN_LEN;
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(LINE_LEN - 1);

    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] pos_nxt;
    hphase_t          phase_nxt;

    // Map a position within the line to its horizontal phase.
    function automatic hphase_t phase_of(input logic [POS_W-1:0] p);
        if (int'(p) < HPL_LEN)        return H_START;
        else if (int'(p) < VCK_START) return H_SETUP;
        else if (int'(p) < VCK_END)   return H_VCLK;
        else if (int'(p) < ROW_START) return H_GAP;
        else if (int'(p) < ROW_END)   return H_ROW;
        else                          return H_TAIL;
    endfunction

    // Position counter: restarts on a line begin, holds at the last position.
    always_comb begin
        if (line_begin)
            pos_nxt = '0;
        else if (pos == POS_LAST)
            pos_nxt = pos;
        else
            pos_nxt = pos + 1'b1;
        phase_nxt = phase_of(pos_nxt);
    end

    // State register: position and phase advance once per tick.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos   <= POS_LAST;
            phase <= H_TAIL;
        end else if (tick) begin
            pos   <= pos_nxt;
            phase <= phase_nxt;
        end
    end

endmodule

// File: rtl/lcdrt_vseq.sv
module lcdrt_vseq
    import lcdrt_pkg::*;
#(
    parameter int FIRST_LINE   = 22,
    parameter int ROWS         = 240,
    parameter int MAX_LINE     = 1023,
    parameter int SKIP_PERIOD  = 6,
    parameter int SKIP_ODD_PH  = 0,
    parameter int SKIP_EVEN_PH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line_start,
    input  logic field_start,
    input  logic field_odd,
    input  logic mode_625,
    output logic row_act,
    output logic row_even,
    output logic row_first
);

    localparam int LINE_W = $clog2(MAX_LINE + 1);
    localparam int ROW_W  = $clog2(ROWS + 1);
    localparam int PH_W   = (SKIP_PERIOD > 1) ? $clog2(SKIP_PERIOD) : 1;

    vstate_t           vstate;
    vstate_t           vstate_nxt;
    logic [LINE_W-1:0] vline;
    logic [LINE_W-1:0] nline;
    logic [ROW_W-1:0]  rcnt;
    logic [PH_W-1:0]   ph;
    logic [PH_W-1:0]   nph;
    logic              odd_f;
    logic              skip;
    logic              rows_full;
    logic              row_nxt;

    // Next line number, drop phase and drop decision for the coming line.
    always_comb begin
        nline     = (vline == LINE_W'(MAX_LINE)) ? vline : vline + 1'b1;
        nph       = (ph == PH_W'(SKIP_PERIOD - 1)) ? '0 : ph + 1'b1;
        skip      = mode_625 && (odd_f ? (nph == PH_W'(SKIP_ODD_PH))
                                       : (nph == PH_W'(SKIP_EVEN_PH)));
        rows_full = (rcnt == ROW_W'(ROWS));
    end

    // Vertical transitions, taken at each line start.
    always_comb begin
        vstate_nxt = vstate;
        row_nxt    = 1'b0;
        unique case (vstate)
            V_BLANK: begin
                if (nline == LINE_W'(FIRST_LINE)) begin
                    vstate_nxt = V_ROWS;
                    row_nxt    = 1'b1;
                end
            end
            V_ROWS: begin
                if (!skip) begin
                    if (rows_full)
                        vstate_nxt = V_DONE;
                    else
                        row_nxt = 1'b1;
                end
            end
            V_DONE: begin
                vstate_nxt = V_DONE;
            end
            default: begin
                vstate_nxt = V_BLANK;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            vstate <= V_BLANK;
        else if (tick && field_start)
            vstate <= V_BLANK;
        else if (tick && line_start)
            vstate <= vstate_nxt;
    end

    // Line, row and drop-phase counters with the row flags they produce.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vline     <= '0;
            rcnt      <= '0;
            ph        <= '0;
            odd_f     <= 1'b0;
            row_act   <= 1'b0;
            row_even  <= 1'b0;
            row_first <= 1'b0;
        end else if (tick && field_start) begin
            vline     <= LINE_W'(1);
            rcnt      <= '0;
            ph        <= '0;
            odd_f     <= field_odd;
            row_act   <= 1'b0;
            row_first <= 1'b0;
        end else if (tick && line_start) begin
            vline     <= nline;
            row_act   <= row_nxt;
            row_first <= (vstate == V_BLANK) && row_nxt;
            ph        <= (vstate == V_BLANK) ? '0 : nph;
            if (row_nxt) begin
                row_even <= ~rcnt[0];
                rcnt     <= rcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lcdrt_strobe.sv
module lcdrt_strobe
    import lcdrt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  hphase_t phase,
    input  logic    row_act,
    input  logic    row_even,
    input  logic    row_first,
    output logic    hck_o,
    output logic    vpl_n,
    output logic    vck_n,
    output logic    hpl_n,
    output logic    rene_n,
    output logic    reno_n
);

    logic vpl_d;
    logic vck_d;
    logic hpl_d;
    logic rene_d;
    logic reno_d;

    // Strobe levels decoded from the registered phase and row flags.
    always_comb begin
        vpl_d  = 1'b1;
        vck_d  = 1'b1;
        hpl_d  = 1'b1;
        rene_d = 1'b1;
        reno_d = 1'b1;
        if (row_act) begin
            unique case (phase)
                H_START: begin
                    hpl_d = 1'b0;
                    vpl_d = !row_first;
                end
                H_SETUP: vpl_d = !row_first;
                H_VCLK:  vck_d = !row_even;
                H_GAP:   ;
                H_ROW: begin
                    rene_d = !row_even;
                    reno_d = row_even;
                end
                H_TAIL:  ;
                default: ;
            endcase
        end
    end

    // Output registers, loaded once per tick.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hck_o  <= 1'b0;
            vpl_n  <= 1'b1;
            vck_n  <= 1'b1;
            hpl_n  <= 1'b1;
            rene_n <= 1'b1;
            reno_n <= 1'b1;
        end else begin
            hck_o <= tick;
            if (tick) begin
                vpl_n  <= vpl_d;
                vck_n  <= vck_d;
                hpl_n  <= hpl_d;
                rene_n <= rene_d;
                reno_n <= reno_d;
            end
        end
    end

endmodule

// File: rtl/lcd_row_timer.sv
module lcd_row_timer
    import lcdrt_pkg::*;
#(
    parameter int LINE_LEN     = 384,
    parameter int HPL_LEN      = 1,
    parameter int VCK_START    = 3,
    parameter int VCK_LEN      = 3,
    parameter int REN_GAP      = 5,
    parameter int REN_LEN      = 332,
    parameter int FIRST_LINE   = 22,
    parameter int ROWS         = 240,
    parameter int MAX_LINE     = 1023,
    parameter int SKIP_PERIOD  = 6,
    parameter int SKIP_ODD_PH  = 0,
    parameter int SKIP_EVEN_PH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hck_en,
    input  logic line_start,
    input  logic field_start,
    input  logic field_odd,
    input  logic mode_625,
    output logic hck_o,
    output logic vpl_n,
    output logic vck_n,
    output logic hpl_n,
    output logic rene_n,
    output logic reno_n
);

    hphase_t phase;
    logic    row_act;
    logic    row_even;
    logic    row_first;
    logic    line_begin;

    assign line_begin = line_start | field_start;

    lcdrt_hphase #(
        .LINE_LEN  (LINE_LEN),
        .HPL_LEN   (HPL_LEN),
        .VCK_START (VCK_START),
        .VCK_LEN   (VCK_LEN),
        .REN_GAP   (REN_GAP),
        .REN_LEN   (REN_LEN)
    ) u_hphase (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (hck_en),
        .line_begin (line_begin),
        .phase      (phase)
    );

    lcdrt_vseq #(
        .FIRST_LINE   (FIRST_LINE),
        .ROWS         (ROWS),
        .MAX_LINE     (MAX_LINE),
        .SKIP_PERIOD  (SKIP_PERIOD),
        .SKIP_ODD_PH  (SKIP_ODD_PH),
        .SKIP_EVEN_PH (SKIP_EVEN_PH)
    ) u_vseq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (hck_en),
        .line_start  (line_start),
        .field_start (field_start),
        .field_odd   (field_odd),
        .mode_625    (mode_625),
        .row_act     (row_act),
        .row_even    (row_even),
        .row_first   (row_first)
    );

    lcdrt_strobe u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (hck_en),
        .phase     (phase),
        .row_act   (row_act),
        .row_even  (row_even),
        .row_first (row_first),
        .hck_o     (hck_o),
        .vpl_n     (vpl_n),
        .vck_n     (vck_n),
        .hpl_n     (hpl_n),
        .rene_n    (rene_n),
        .reno_n    (reno_n)
    );

endmodule

// File: rtl/lcd_row_timer_chk.sv
module lcd_row_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic hck_en,
    input logic hck_o,
    input logic vpl_n,
    input logic vck_n,
    input logic hpl_n,
    input logic rene_n,
    input logic reno_n
);

    // R2: strobes move only on the edge that samples a tick.
    assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hck_en) |-> $stable({vpl_n, vck_n, hpl_n, rene_n, reno_n}));

    // R7: even and odd row enables are exclusive.
    assert_row_enables_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!rene_n, !reno_n}) <= 1);

    // R7: a row enable begins only after the row start and row-pair clock are released.
    assert_ren_after_hpl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rene_n) || $fell(reno_n)) |-> (hpl_n && vck_n));

    // R6: the row-pair clock never overlaps a row enable.
    assert_vck_clear_of_rows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !vck_n |-> (rene_n && reno_n));

    // R5: the field-start pulse begins together with a row start pulse.
    assert_vpl_with_hpl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vpl_n) |-> !hpl_n);

    // R10: the panel clock follows each tick by one cycle.
    assert_hck_follows_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hck_en |=> hck_o);

    assert_hck_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !hck_en |=> !hck_o);

endmodule

bind lcd_row_timer lcd_row_timer_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .hck_en (hck_en),
    .hck_o  (hck_o),
    .vpl_n  (vpl_n),
    .vck_n  (vck_n),
    .hpl_n  (hpl_n),
    .rene_n (rene_n),
    .reno_n (reno_n)
);

// File: tb/lcd_row_timer_test.sv
module lcd_row_timer_test;

    localparam int CLK_PERIOD = 10;
    localparam int SHORT      = 6;
    localparam int LONG_K     = 390;
    localparam int NVEC       = 17;

    // {mode_625, field_odd, line, kind}; kind 0 none, 1 row 0, 2 even row, 3 odd row
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 10'd21,  2'd0},
        {1'b0, 1'b1, 10'd22,  2'd1},
        {1'b0, 1'b1, 10'd23,  2'd3},
        {1'b0, 1'b0, 10'd24,  2'd2},
        {1'b0, 1'b1, 10'd260, 2'd2},
        {1'b0, 1'b0, 10'd261, 2'd3},
        {1'b0, 1'b1, 10'd262, 2'd0},
        {1'b1, 1'b0, 10'd22,  2'd1},
        {1'b1, 1'b1, 10'd27,  2'd3},
        {1'b1, 1'b1, 10'd28,  2'd0},
        {1'b1, 1'b1, 10'd29,  2'd2},
        {1'b1, 1'b0, 10'd25,  2'd0},
        {1'b1, 1'b0, 10'd26,  2'd3},
        {1'b1, 1'b1, 10'd308, 2'd3},
        {1'b1, 1'b1, 10'd309, 2'd0},
        {1'b1, 1'b0, 10'd307, 2'd0},
        {1'b1, 1'b0, 10'd309, 2'd3}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hck_en = 1'b0;
    logic line_start = 1'b0;
    logic field_start = 1'b0;
    logic field_odd = 1'b0;
    logic mode_625 = 1'b0;
    logic hck_o, vpl_n, vck_n, hpl_n, rene_n, reno_n;

    int n_chk = 0;
    int n_bad = 0;
    int gap = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lcd_row_timer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .hck_en      (hck_en),
        .line_start  (line_start),
        .field_start (field_start),
        .field_odd   (field_odd),
        .mode_625    (mode_625),
        .hck_o       (hck_o),
        .vpl_n       (vpl_n),
        .vck_n       (vck_n),
        .hpl_n       (hpl_n),
        .rene_n      (rene_n),
        .reno_n      (reno_n)
    );

    // Called at a falling edge: one tick, then the idle gap.
    task automatic tick(input logic ls, input logic fs);
        hck_en      = 1'b1;
        line_start  = ls;
        field_start = fs;
        @(negedge clk);
        hck_en      = 1'b0;
        line_start  = 1'b0;
        field_start = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic chk(input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin : main
        logic       m, o;
        logic [9:0] ln;
        logic [1:0] kd;
        string      tag;
        string      ctx;
        logic       row, first, ev, od;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 hck_o in reset", hck_o, 1'b0);
        chk("R1 vpl_n in reset", vpl_n, 1'b1);
        chk("R1 vck_n in reset", vck_n, 1'b1);
        chk("R1 hpl_n in reset", hpl_n, 1'b1);
        chk("R1 rene_n in reset", rene_n, 1'b1);
        chk("R1 reno_n in reset", reno_n, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        // Table of line cases, each reached through a field of short lines.
        for (int i = 0; i < NVEC; i++) begin
            {m, o, ln, kd} = VEC[i];
            gap       = i % 2;
            mode_625  = m;
            field_odd = o;
            tag = m ? "R8" : ((kd == 2'd0) ? "R9" : "R3");
            tick(1'b1, 1'b1);
            repeat (SHORT - 1) tick(1'b0, 1'b0);
            for (int l = 2; l < int'(ln); l++) begin
                tick(1'b1, 1'b0);
                repeat (SHORT - 1) tick(1'b0, 1'b0);
            end
            tick(1'b1, 1'b0);
            row   = (kd != 2'd0);
            first = (kd == 2'd1);
            ev    = (kd == 2'd1) || (kd == 2'd2);
            od    = (kd == 2'd3);
            for (int k = 1; k <= LONG_K; k++) begin
                tick(1'b0, 1'b0);
                ctx = $sformatf("%s%s line %0d odd %0d mode %0d k %0d",
                                tag, (k > 384) ? " R11" : "", ln, o, m, k);
                chk({"R2 R4 hpl_n ", ctx}, hpl_n, !(row && k == 1));
                chk({"R5 vpl_n ", ctx}, vpl_n, !(first && k >= 1 && k <= 3));
                chk({"R6 vck_n ", ctx}, vck_n, !(ev && k >= 4 && k <= 6));
                chk({"R7 rene_n ", ctx}, rene_n, !(ev && k >= 7 && k <= 338));
                chk({"R7 reno_n ", ctx}, reno_n, !(od && k >= 7 && k <= 338));
            end
        end

        // R10: hck_o high the cycle after a tick, low the cycle after that.
        gap = 0;
        hck_en = 1'b1;
        @(negedge clk);
        hck_en = 1'b0;
        chk("R10 hck_o after tick", hck_o, 1'b1);
        @(negedge clk);
        chk("R10 hck_o without tick", hck_o, 1'b0);

        // R1: reset in the middle of a row enable clears the strobes at once.
        mode_625  = 1'b0;
        field_odd = 1'b1;
        tick(1'b1, 1'b1);
        for (int l = 2; l < 22; l++) tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        repeat (10) tick(1'b0, 1'b0);
        chk("R7 rene_n low before mid-row reset", rene_n, 1'b0);
        #1 rst_n = 1'b0;
        #1;
        chk("R1 rene_n async reset", rene_n, 1'b1);
        chk("R1 hpl_n async reset", hpl_n, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        repeat (4) tick(1'b0, 1'b0);
        chk("R1 rene_n stays high after reset", rene_n, 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule